// File: doc/BRIEF.md
# Per-Platter Write-Protect Status Logic

This block holds the write-protect state of a two-platter disk drive. Each platter has a protect switch. The switch level is brought into the clock domain through a two-flop synchronizer. It is then debounced by a small state machine, and the debounced result is held in a per-platter protect latch. Each protect latch drives that platter's front-panel lamp directly. A configuration strap for each platter forces its latch to the unprotected state. A single-disk build straps the lower platter, and a build with no switches fitted straps both platters.

The host selects a platter with a select line that comes in true and complement forms. The selected platter's latch value is routed to a file-protect mode latch, and that latch drives the file-protected status line. The mode latch loads only while neither a write nor an erase is in progress. During an operation it holds its value, so the reported protection cannot change part-way through. It takes the current selection on the first clock edge after the operation ends.

Debouncer states: `DB_STEADY` (the synchronized input equals the latch) and `DB_VERIFY` (a differing level is being timed). There are three transitions. STEADY to VERIFY happens on a difference. VERIFY to STEADY happens either when the level reverts, with no change to the latch, or when the count completes, which loads the latch. A strap forces any state to STEADY. Mode-latch states: `FP_TRACK` (no operation, so the latch loads every clock) and `FP_FROZEN` (a write or erase is active, so the latch holds). The block enters FROZEN when the operation starts and returns to TRACK when it ends.

Top module: `wp_status`

## Requirements
- R1: While the synchronous reset `rst` is high, both lamps and `file_protected` are driven low from the next clock edge onward, and all latches are cleared to unprotected.
- R2: A switch input (1 = protect) held at a new level changes its lamp (1 = lit = protected) on exactly the (DEB_CYC+2)th rising edge, counting the first edge that samples the new level. This covers 2 synchronizer edges and DEB_CYC debounce edges, with DEB_CYC of at least 2.
- R3: A switch pulse that lasts fewer than DEB_CYC clocks leaves the lamp unchanged.
- R4: While a platter's strap input is 1, its latch is cleared on the next edge and held unprotected, whatever its switch does. After the strap is released with the switch still at 1, the lamp lights on the DEB_CYC-th edge after release.
- R5: The routed value is the lower-platter latch (index 1) when `sel_lower`=1 and `sel_lower_n`=0, and the upper-platter latch (index 0) when `sel_lower`=0 and `sel_lower_n`=1. When both select inputs are 1 the routed value is the OR of the two latches. When both are 0 it is unprotected.
- R6: On every edge where neither `wr_active` nor `erase_active` is 1, `file_protected` loads the routed value, so it takes effect one clock later.
- R7: While `wr_active` or `erase_active` is 1, `file_protected` holds its value through switch toggles, strap changes and select changes.
- R8: On the first edge where both operation flags are low after an operation, `file_protected` takes the currently routed value.
- R9: The lamps follow their latches whatever the select inputs and operation flags are doing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sw_prot | input | 2 | Raw protect switches, index 0 upper, 1 lower; 1 = protect |
| strap_dis | input | 2 | Per-platter disable straps; 1 = force unprotected |
| sel_lower | input | 1 | Platter select, true form |
| sel_lower_n | input | 1 | Platter select, complement form |
| wr_active | input | 1 | Write in progress |
| erase_active | input | 1 | Erase in progress |
| lamp_on | output | 2 | Front-panel protect lamp drive per platter |
| file_protected | output | 1 | Protect status of the selected platter |

## Verification
The hardest case to reach is a switch that finishes debouncing while an operation is active, combined with a select change during the same operation. This requires a write or erase to stay high for more than DEB_CYC+2 clocks, which random flag toggling rarely produces. Directed sequences therefore hold a write, then hand over to an overlapping erase. During that time they flip a switch and the select, check every cycle that the status is frozen, and then check the first edge after release. Random traffic with slow switch changes and run-length operation flags is compared each cycle against a bench reference model.

// File: rtl/wp_pkg.sv
package wp_pkg;
    localparam int PLATTERS = 2;

    typedef enum logic {
        DB_STEADY = 1'b0,
        DB_VERIFY = 1'b1
    } db_state_t;

    typedef enum logic {
        FP_TRACK  = 1'b0,
        FP_FROZEN = 1'b1
    } fp_state_t;
endpackage

// File: rtl/wp_sync2.sv
module wp_sync2 #(
    parameter int W = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta_q;
    logic [W-1:0] sync_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= d;
            sync_q <= meta_q;
        end
    end

    assign q = sync_q;
endmodule

// File: rtl/wp_debounce.sv
module wp_debounce
    import wp_pkg::*;
#(
    parameter int DEB_CYC = 4
) (
    input  logic clk,
    input  logic rst,
    input  logic lvl,
    input  logic strap,
    output logic prot
);
    localparam int CW = $clog2(DEB_CYC + 1);
    localparam logic [CW-1:0] LAST = CW'(DEB_CYC - 1);

    db_state_t      st_q, st_d;
    logic [CW-1:0]  cnt_q, cnt_d;
    logic           lat_q, lat_d;

    always_comb begin
        st_d  = st_q;
        cnt_d = cnt_q;
        lat_d = lat_q;
        if (strap) begin
            st_d  = DB_STEADY;
            cnt_d = '0;
            lat_d = 1'b0;
        end else begin
            unique case (st_q)
                DB_STEADY: begin
                    if (lvl != lat_q) begin
                        st_d  = DB_VERIFY;
                        cnt_d = CW'(1);
                    end
                end
                DB_VERIFY: begin
                    if (lvl == lat_q) begin
                        st_d  = DB_STEADY;
                        cnt_d = '0;
                    end else if (cnt_q == LAST) begin
                        lat_d = lvl;
                        st_d  = DB_STEADY;
                        cnt_d = '0;
                    end else begin
                        cnt_d = cnt_q + 1'b1;
                    end
                end
                default: st_d = DB_STEADY;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q  <= DB_STEADY;
            cnt_q <= '0;
            lat_q <= 1'b0;
        end else begin
            st_q  <= st_d;
            cnt_q <= cnt_d;
            lat_q <= lat_d;
        end
    end

    assign prot = lat_q;

    // R4: strap clears the latch on the next edge
    assert_strap_clears_R4: assert property (@(posedge clk) disable iff (rst)
        strap |=> !lat_q);

    // R2: the latch only ever moves to the level it was comparing against
    assert_latch_moves_to_input_R2: assert property (@(posedge clk) disable iff (rst)
        !strap |=> (lat_q == $past(lat_q)) || (lat_q == $past(lvl)));

    // R3: a latch change is always preceded by a verify state
    assert_change_needs_verify_R3: assert property (@(posedge clk) disable iff (rst)
        (!strap && st_q == DB_STEADY) |=> (lat_q == $past(lat_q)));
endmodule

// File: rtl/wp_fp_mode.sv
module wp_fp_mode
    import wp_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic [PLATTERS-1:0] prot,
    input  logic                sel_lower,
    input  logic                sel_lower_n,
    input  logic                wr_active,
    input  logic                erase_active,
    output logic                fp
);
    fp_state_t st_q, st_d;
    logic      busy;
    logic      routed;
    logic      fp_q, fp_d;

    assign busy   = wr_active | erase_active;
    assign routed = (sel_lower & prot[1]) | (sel_lower_n & prot[0]);

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            FP_TRACK:  if (busy)  st_d = FP_FROZEN;
            FP_FROZEN: if (!busy) st_d = FP_TRACK;
            default:   st_d = FP_TRACK;
        endcase
    end

    always_comb begin
        fp_d = fp_q;
        if (!busy) fp_d = routed;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= FP_TRACK;
            fp_q <= 1'b0;
        end else begin
            st_q <= st_d;
            fp_q <= fp_d;
        end
    end

    assign fp = fp_q;

    // R7: frozen while an operation is active
    assert_hold_during_op_R7: assert property (@(posedge clk) disable iff (rst)
        (wr_active || erase_active) |=> $stable(fp_q));

    // R6: loads the routed latch when idle
    assert_load_when_idle_R6: assert property (@(posedge clk) disable iff (rst)
        (!wr_active && !erase_active) |=> (fp_q == $past(routed)));

    // R8: first idle edge after an operation takes the current selection
    assert_resume_after_op_R8: assert property (@(posedge clk) disable iff (rst)
        (st_q == FP_FROZEN && !wr_active && !erase_active) |=> (fp_q == $past(routed) && st_q == FP_TRACK));
endmodule

// File: rtl/wp_status.sv
module wp_status
    import wp_pkg::*;
#(
    parameter int DEB_CYC = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] sw_prot,
    input  logic [1:0] strap_dis,
    input  logic       sel_lower,
    input  logic       sel_lower_n,
    input  logic       wr_active,
    input  logic       erase_active,
    output logic [1:0] lamp_on,
    output logic       file_protected
);
    logic [PLATTERS-1:0] sw_sync;
    logic [PLATTERS-1:0] prot;

    wp_sync2 #(.W(PLATTERS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (sw_prot),
        .q   (sw_sync)
    );

    for (genvar p = 0; p < PLATTERS; p++) begin : g_plat
        wp_debounce #(.DEB_CYC(DEB_CYC)) u_deb (
            .clk   (clk),
            .rst   (rst),
            .lvl   (sw_sync[p]),
            .strap (strap_dis[p]),
            .prot  (prot[p])
        );
    end

    wp_fp_mode u_mode (
        .clk          (clk),
        .rst          (rst),
        .prot         (prot),
        .sel_lower    (sel_lower),
        .sel_lower_n  (sel_lower_n),
        .wr_active    (wr_active),
        .erase_active (erase_active),
        .fp           (file_protected)
    );

    assign lamp_on = prot;

    // R1: reset clears lamps and status
    assert_reset_clear_R1: assert property (@(posedge clk)
        rst |=> (lamp_on == 2'b00 && !file_protected));
endmodule

// File: tb/wp_status_bench.sv
module wp_status_bench;
    localparam int CLK_NS  = 10;
    localparam int DEB_CYC = 4;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] sw_prot = '0;
    logic [1:0] strap_dis = '0;
    logic       sel_lower = 1'b0;
    logic       sel_lower_n = 1'b1;
    logic       wr_active = 1'b0;
    logic       erase_active = 1'b0;
    logic [1:0] lamp_on;
    logic       file_protected;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    wp_status #(.DEB_CYC(DEB_CYC)) u_wp_status (
        .clk(clk), .rst(rst), .sw_prot(sw_prot), .strap_dis(strap_dis),
        .sel_lower(sel_lower), .sel_lower_n(sel_lower_n),
        .wr_active(wr_active), .erase_active(erase_active),
        .lamp_on(lamp_on), .file_protected(file_protected)
    );

    always #(CLK_NS/2) clk = ~clk;

    // Reference model built from the requirements
    logic [1:0] m_s1, m_s2, m_lat;
    logic       m_fp;
    int         m_cnt [2];

    function automatic logic route_exp(logic [1:0] lat, logic s, logic sn);
        return (s & lat[1]) | (sn & lat[0]);
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_s1 <= '0; m_s2 <= '0; m_lat <= '0; m_fp <= 1'b0;
            m_cnt[0] <= 0; m_cnt[1] <= 0;
        end else begin
            m_s1 <= sw_prot;
            m_s2 <= m_s1;
            for (int p = 0; p < 2; p++) begin
                if (strap_dis[p]) begin
                    m_lat[p] <= 1'b0; m_cnt[p] <= 0;
                end else if (m_s2[p] == m_lat[p]) begin
                    m_cnt[p] <= 0;
                end else if (m_cnt[p] == DEB_CYC - 1) begin
                    m_lat[p] <= m_s2[p]; m_cnt[p] <= 0;
                end else begin
                    m_cnt[p] <= m_cnt[p] + 1;
                end
            end
            if (!(wr_active || erase_active))
                m_fp <= route_exp(m_lat, sel_lower, sel_lower_n);
        end
    end

    task automatic check(input logic got, input logic exp, input string req);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: got %0b expected %0b at %0t", req, got, exp, $time);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #(CLK_NS * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: got timeout expected completion");
            summary();
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        cyc(3);
        // R1: reset state
        check(lamp_on[0], 1'b0, "R1 lamp0");
        check(lamp_on[1], 1'b0, "R1 lamp1");
        check(file_protected, 1'b0, "R1 status");
        rst = 1'b0;
        cyc(2);

        // R2: exact latency of a switch change to the lamp
        sw_prot[0] = 1'b1;
        repeat (DEB_CYC + 1) @(posedge clk);
        @(negedge clk);
        check(lamp_on[0], 1'b0, "R2 lamp0 before");
        @(negedge clk);
        check(lamp_on[0], 1'b1, "R2 lamp0 at edge");
        check(file_protected, 1'b0, "R6 status not yet");
        @(negedge clk);
        check(file_protected, 1'b1, "R6 status one clock later");

        // R3: short pulse rejected
        sw_prot[1] = 1'b1;
        cyc(DEB_CYC - 1);
        sw_prot[1] = 1'b0;
        cyc(DEB_CYC + 6);
        check(lamp_on[1], 1'b0, "R3 glitch ignored");

        // R5: selection routing, lat = {0,1}
        sel_lower = 1'b1; sel_lower_n = 1'b0; cyc(1);
        check(file_protected, 1'b0, "R5 lower selected");
        sel_lower = 1'b0; sel_lower_n = 1'b1; cyc(1);
        check(file_protected, 1'b1, "R5 upper selected");
        sel_lower = 1'b0; sel_lower_n = 1'b0; cyc(1);
        check(file_protected, 1'b0, "R5 none selected");
        sel_lower = 1'b1; sel_lower_n = 1'b1; cyc(1);
        check(file_protected, 1'b1, "R5 both selected OR");
        sel_lower = 1'b0; sel_lower_n = 1'b1; cyc(1);

        // R7: freeze through write then overlapping erase
        wr_active = 1'b1;
        sw_prot[0] = 1'b0;
        sel_lower = 1'b1; sel_lower_n = 1'b0;
        for (int i = 0; i < DEB_CYC + 6; i++) begin
            cyc(1);
            check(file_protected, 1'b1, "R7 hold during write");
        end
        check(lamp_on[0], 1'b0, "R9 lamp follows during write");
        erase_active = 1'b1; cyc(1);
        wr_active = 1'b0;
        sw_prot[1] = 1'b1;
        for (int i = 0; i < DEB_CYC + 4; i++) begin
            cyc(1);
            check(file_protected, 1'b1, "R7 hold during erase");
        end
        check(lamp_on[1], 1'b1, "R9 lamp1 follows during erase");
        erase_active = 1'b0;
        cyc(1);
        check(file_protected, 1'b1, "R8 first edge after op");
        sel_lower = 1'b0; sel_lower_n = 1'b1;
        cyc(1);
        check(file_protected, 1'b0, "R8 tracking resumed");

        // R4: strap forces unprotected and release relights
        strap_dis[1] = 1'b1; cyc(1);
        check(lamp_on[1], 1'b0, "R4 strap clears");
        cyc(DEB_CYC + 4);
        check(lamp_on[1], 1'b0, "R4 strap holds");
        strap_dis[1] = 1'b0;
        repeat (DEB_CYC - 1) @(posedge clk);
        @(negedge clk);
        check(lamp_on[1], 1'b0, "R4 before relight");
        @(negedge clk);
        check(lamp_on[1], 1'b1, "R4 relight");

        // Random traffic against the reference model
        for (int i = 0; i < 4000; i++) begin
            cyc(1);
            check(lamp_on[0], m_lat[0], "R2 R9 random lamp0");
            check(lamp_on[1], m_lat[1], "R2 R9 random lamp1");
            check(file_protected, m_fp, "R6 R7 random status");
            if ($urandom_range(15) == 0) sw_prot[0] = ~sw_prot[0];
            if ($urandom_range(15) == 0) sw_prot[1] = ~sw_prot[1];
            if ($urandom_range(3) == 0) sw_prot[$urandom_range(1)] ^= ($urandom_range(7) == 0);
            if ($urandom_range(63) == 0) strap_dis[$urandom_range(1)] ^= 1'b1;
            if ($urandom_range(7) == 0) begin
                sel_lower = 1'($urandom_range(1));
                sel_lower_n = ($urandom_range(7) == 0) ? sel_lower : ~sel_lower;
            end
            if ($urandom_range(11) == 0) wr_active = ~wr_active;
            if ($urandom_range(13) == 0) erase_active = ~erase_active;
        end

        // R1: reset mid-run
        rst = 1'b1; cyc(2);
        check(lamp_on[0], 1'b0, "R1 re-reset lamp0");
        check(lamp_on[1], 1'b0, "R1 re-reset lamp1");
        check(file_protected, 1'b0, "R1 re-reset status");

        done = 1'b1;
        summary();
        $finish;
    end
endmodule